// File: doc/BRIEF.md
# Tagged Two-Bit Branch History Table

This block is a direct-mapped table of branch records that a fetch stage consults on every cycle. Each record holds the upper address bits of a branch (its tag), a small history state and the address the branch jumped to last time. A lookup with the fetch address reports whether a record matches, whether the branch is expected to jump, and the next fetch address. That address is the stored target when a jump is expected, and the next sequential word otherwise. Fetch can therefore redirect without waiting for decode to produce the target.

When a branch resolves later in the pipeline, the update port carries its address, its actual direction and its actual target. A matching record has its history advanced and, on a jump, its target refreshed. A non-matching record is overwritten with a fresh record for the new branch. By default the history is a saturating two-bit state, so a strongly established direction survives one contrary outcome. A parameter selects a one-bit history that simply follows the last outcome, so the two schemes can be compared.

Top module: `bht_predictor`

## Requirements
- R1: After reset every record is empty: every lookup misses, reports not-taken, and gives the next sequential address as target.
- R2: On a lookup miss, `lk_hit`=0, `lk_taken`=0 and `lk_target` = `lk_pc` + 2^OFS_W (the next word).
- R3: The record index is `pc[OFS_W+IDX_W-1:OFS_W]` and the tag is `pc[PC_W-1:OFS_W+IDX_W]`. Two addresses that share an index but differ in tag never hit each other's record. An update that misses replaces the record in that slot.
- R4: In two-bit mode an update that misses allocates the record in a weak state: weak-taken (encoding 2'b10) if the branch jumped, weak-not-taken (2'b01) otherwise. A single contrary outcome then flips the prediction.
- R5: On a hit, a jump is predicted in the two taken states (strong-taken 2'b11, weak-taken 2'b10). The target is then the stored target, and otherwise the next word.
- R6: In two-bit mode the state is a saturating counter, moved one step toward taken on a jump and toward not-taken otherwise. From a strong state the prediction reverses only after two consecutive contrary outcomes.
- R7: Allocation stores the supplied target. On a hit, a taken resolution replaces the stored target and a not-taken resolution leaves it unchanged.
- R8: A lookup that hits the record being updated in the same cycle returns the state and target held before that update.
- R9: With ONE_BIT=1 the prediction on a hit equals the direction of the most recent resolution of that record.
- R10: The low OFS_W address bits take no part in index or tag. A lookup at a byte offset inside a recorded word hits that record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | Fetch address to look up |
| up_en | input | 1 | A resolved branch is presented this cycle |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Resolved direction, 1 = jumped |
| up_target | input | PC_W | Resolved target address |
| lk_hit | output | 1 | Lookup matched a valid record |
| lk_taken | output | 1 | Jump predicted |
| lk_target | output | PC_W | Predicted next fetch address |

## Verification
The hardest situation to reach from the ports is the hysteresis corner: a record must first be driven into a strong state by repeated jumps before one contrary outcome can show that the prediction holds, and a second one that it flips. A record must also be evicted by a different tag in the same slot while its old owner is still looked up. The stimulus builds these histories with directed sequences. It then runs a long pseudo-random stream of resolutions over every slot and three tags per slot, and sweeps all twelve addresses after every update against a bench-side model of both history schemes. Every update also checks the same-cycle lookup of the address being updated, which covers R8 from any state.

// File: rtl/bht_pkg.sv
package bht_pkg;

  typedef enum logic [1:0] {
    ST_SNT = 2'b00,
    ST_WNT = 2'b01,
    ST_WT  = 2'b10,
    ST_ST  = 2'b11
  } bht_state_e;

  // Direction predicted by a history state.
  function automatic logic bht_predict(input bht_state_e s);
    return (s == ST_ST) || (s == ST_WT);
  endfunction

  // State given to a freshly allocated record.
  function automatic bht_state_e bht_init(input logic taken, input logic one_bit);
    if (one_bit) return taken ? ST_ST : ST_SNT;
    return taken ? ST_WT : ST_WNT;
  endfunction

  // History advance on a resolution that hit the record.
  function automatic bht_state_e bht_next(input bht_state_e s, input logic taken,
                                          input logic one_bit);
    logic [1:0] v;
    if (one_bit) return taken ? ST_ST : ST_SNT;
    v = s;
    if (taken) v = (v == 2'b11) ? v : v + 2'd1;
    else       v = (v == 2'b00) ? v : v - 2'd1;
    return bht_state_e'(v);
  endfunction

endpackage

// File: rtl/bht_addr_split.sv
module bht_addr_split #(
  parameter int PC_W  = 32,
  parameter int OFS_W = 2,
  parameter int IDX_W = 4,
  localparam int TAG_W = PC_W - OFS_W - IDX_W
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx,
  output logic [TAG_W-1:0] tag
);
  assign idx = pc[OFS_W +: IDX_W];
  assign tag = pc[PC_W-1 -: TAG_W];

  logic unused_ofs;
  assign unused_ofs = ^pc[OFS_W-1:0];
endmodule

// File: rtl/bht_store.sv
module bht_store
  import bht_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 26,
  parameter int PC_W    = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  // lookup read port
  input  logic [IDX_W-1:0] ra_idx,
  output logic             ra_valid,
  output logic [TAG_W-1:0] ra_tag,
  output bht_state_e       ra_state,
  output logic [PC_W-1:0]  ra_target,
  // update read port
  input  logic [IDX_W-1:0] rb_idx,
  output logic             rb_valid,
  output logic [TAG_W-1:0] rb_tag,
  output bht_state_e       rb_state,
  // write port
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  bht_state_e       wr_state,
  input  logic             wr_tgt_en,
  input  logic [PC_W-1:0]  wr_target
);
  logic             valid_q [ENTRIES];
  logic [TAG_W-1:0] tag_q   [ENTRIES];
  bht_state_e       st_q    [ENTRIES];
  logic [PC_W-1:0]  tgt_q   [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_rec
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(e));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[e] <= 1'b0;
        tag_q[e]   <= '0;
        st_q[e]    <= ST_SNT;
        tgt_q[e]   <= '0;
      end else if (sel) begin
        valid_q[e] <= 1'b1;
        tag_q[e]   <= wr_tag;
        st_q[e]    <= wr_state;
        if (wr_tgt_en) tgt_q[e] <= wr_target;
      end
    end
  end

  assign ra_valid  = valid_q[ra_idx];
  assign ra_tag    = tag_q[ra_idx];
  assign ra_state  = st_q[ra_idx];
  assign ra_target = tgt_q[ra_idx];
  assign rb_valid  = valid_q[rb_idx];
  assign rb_tag    = tag_q[rb_idx];
  assign rb_state  = st_q[rb_idx];

  // A written record becomes valid with the written tag and state (R3)
  assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> valid_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag)
              && st_q[$past(wr_idx)] == $past(wr_state));

  // A not-taken hit leaves the stored target alone (R7)
  assert_target_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_tgt_en) |=> tgt_q[$past(wr_idx)] == $past(tgt_q[wr_idx]));
endmodule

// File: rtl/bht_predictor.sv
module bht_predictor
  import bht_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 16,
  parameter int OFS_W   = 2,
  parameter bit ONE_BIT = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  input  logic            up_en,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken,
  input  logic [PC_W-1:0] up_target,
  output logic            lk_hit,
  output logic            lk_taken,
  output logic [PC_W-1:0] lk_target
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = PC_W - OFS_W - IDX_W;
  localparam logic [PC_W-1:0] WORD = PC_W'(1) << OFS_W;

  function automatic logic [PC_W-1:0] seq_next(input logic [PC_W-1:0] pc);
    return pc + WORD;
  endfunction

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag;

  bht_addr_split #(.PC_W(PC_W), .OFS_W(OFS_W), .IDX_W(IDX_W)) u_split_lk (
    .pc(lk_pc), .idx(lk_idx), .tag(lk_tag));
  bht_addr_split #(.PC_W(PC_W), .OFS_W(OFS_W), .IDX_W(IDX_W)) u_split_up (
    .pc(up_pc), .idx(up_idx), .tag(up_tag));

  logic             ra_valid, rb_valid;
  logic [TAG_W-1:0] ra_tag, rb_tag;
  bht_state_e       lk_state, up_state, wr_state;
  logic [PC_W-1:0]  ra_target;
  logic             up_hit, wr_tgt_en;

  // named internal events
  assign lk_hit    = ra_valid && (ra_tag == lk_tag);
  assign up_hit    = rb_valid && (rb_tag == up_tag);
  assign wr_state  = up_hit ? bht_next(up_state, up_taken, ONE_BIT)
                            : bht_init(up_taken, ONE_BIT);
  assign wr_tgt_en = !up_hit || up_taken;

  assign lk_taken  = lk_hit && bht_predict(lk_state);
  assign lk_target = lk_taken ? ra_target : seq_next(lk_pc);

  bht_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .PC_W(PC_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .ra_idx(lk_idx), .ra_valid(ra_valid), .ra_tag(ra_tag),
    .ra_state(lk_state), .ra_target(ra_target),
    .rb_idx(up_idx), .rb_valid(rb_valid), .rb_tag(rb_tag), .rb_state(up_state),
    .wr_en(up_en), .wr_idx(up_idx), .wr_tag(up_tag), .wr_state(wr_state),
    .wr_tgt_en(wr_tgt_en), .wr_target(up_target));

  // A miss falls through to the next word, never jumps (R2)
  assert_miss_sequential_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (!lk_taken && lk_target == lk_pc + WORD));

  // Allocation lands in a weak state matching the outcome (R4)
  assert_alloc_weak_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ONE_BIT && up_en && !up_hit) |->
      ((wr_state == ST_WT || wr_state == ST_WNT) && bht_predict(wr_state) == up_taken));

  // Direction reverses only from a weak state (R6)
  assert_flip_from_weak_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ONE_BIT && up_en && up_hit && bht_predict(wr_state) != bht_predict(up_state)) |->
      (up_state == ST_WT || up_state == ST_WNT));

  // One-bit records hold only the two strong codes (R9)
  assert_one_bit_states_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ONE_BIT && lk_hit) |-> (lk_state == ST_ST || lk_state == ST_SNT));
endmodule

// File: tb/tb_bht_predictor.sv
`timescale 1ns/1ps
module tb_bht_predictor;
  localparam int PC_W = 16;
  localparam int ENT  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PC_W-1:0] lk_pc = '0, up_pc = '0, up_target = '0;
  logic up_en = 1'b0, up_taken = 1'b0;
  logic hit2, tk2, hit1, tk1;
  logic [PC_W-1:0] tg2, tg1;

  always #2 clk = ~clk;  // 250 MHz

  bht_predictor #(.PC_W(PC_W), .ENTRIES(ENT), .OFS_W(2), .ONE_BIT(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .up_en(up_en), .up_pc(up_pc),
    .up_taken(up_taken), .up_target(up_target),
    .lk_hit(hit2), .lk_taken(tk2), .lk_target(tg2));
  bht_predictor #(.PC_W(PC_W), .ENTRIES(ENT), .OFS_W(2), .ONE_BIT(1'b1)) dut_1b (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .up_en(up_en), .up_pc(up_pc),
    .up_taken(up_taken), .up_target(up_target),
    .lk_hit(hit1), .lk_taken(tk1), .lk_target(tg1));

  int checks = 0, errors = 0;

  // bench model
  bit        m_val [ENT];
  int        m_tag [ENT];
  int        m_cnt [ENT];
  bit        m_lb  [ENT];
  int        m_tgt [ENT];

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s pc=%h actual=%h expected=%h", req, what, lk_pc, got, exp);
    end
  endtask

  task automatic check_pc(input logic [PC_W-1:0] pc, input string req);
    int i, t;
    bit h, e2, e1;
    lk_pc = pc;
    #0.1;
    i  = int'(pc[3:2]);
    t  = int'(pc[15:4]);
    h  = m_val[i] && (m_tag[i] == t);
    e2 = h && (m_cnt[i] >= 2);
    e1 = h && m_lb[i];
    chk(req, "hit", int'(hit2), int'(h));
    chk(req, "taken", int'(tk2), int'(e2));
    chk(req, "target", int'(tg2), e2 ? m_tgt[i] : int'(16'(pc + 16'd4)));
    chk(req, "hit1b", int'(hit1), int'(h));
    chk(req, "taken1b", int'(tk1), int'(e1));
    chk(req, "target1b", int'(tg1), e1 ? m_tgt[i] : int'(16'(pc + 16'd4)));
  endtask

  task automatic upd(input logic [PC_W-1:0] pc, input bit tk,
                     input logic [PC_W-1:0] tgt, input string req);
    int i, t;
    @(negedge clk);
    up_en = 1'b1; up_pc = pc; up_taken = tk; up_target = tgt;
    #0.5;
    check_pc(pc, "R8");  // same-cycle lookup sees pre-update record
    @(posedge clk);
    i = int'(pc[3:2]);
    t = int'(pc[15:4]);
    if (m_val[i] && m_tag[i] == t) begin
      m_cnt[i] = tk ? ((m_cnt[i] == 3) ? 3 : m_cnt[i] + 1)
                    : ((m_cnt[i] == 0) ? 0 : m_cnt[i] - 1);
      if (tk) m_tgt[i] = int'(tgt);
    end else begin
      m_val[i] = 1'b1; m_tag[i] = t;
      m_cnt[i] = tk ? 2 : 1;
      m_tgt[i] = int'(tgt);
    end
    m_lb[i] = tk;
    @(negedge clk);
    up_en = 1'b0;
    #0.5;
    check_pc(pc, req);
  endtask

  function automatic logic [PC_W-1:0] mk(input int tag, input int idx);
    return {12'(tag), 2'(idx), 2'b00};
  endfunction

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < ENT; i++) begin
      m_val[i] = 0; m_tag[i] = 0; m_cnt[i] = 0; m_lb[i] = 0; m_tgt[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #0.5;
    // R1: empty after reset, every slot misses (R2 sequential target)
    for (int i = 0; i < ENT; i++) check_pc(mk(5, i), "R1");
    check_pc(16'hFFFC, "R2");

    // R4: taken allocation predicts taken with stored target (R5)
    upd(mk(1, 1), 1'b1, 16'h4A00, "R4");
    // one contrary outcome flips a weak record (R4), one-bit follows it (R9)
    upd(mk(1, 1), 1'b0, 16'h1111, "R4");
    // not-taken allocation
    upd(mk(2, 2), 1'b0, 16'h2200, "R4");
    check_pc(mk(2, 2), "R5");

    // R6: drive to strong-taken then two contrary outcomes
    upd(mk(3, 0), 1'b1, 16'h3000, "R6");
    upd(mk(3, 0), 1'b1, 16'h3000, "R6");
    upd(mk(3, 0), 1'b1, 16'h3000, "R6");
    upd(mk(3, 0), 1'b0, 16'h0000, "R6");  // still taken in two-bit mode
    upd(mk(3, 0), 1'b0, 16'h0000, "R6");  // now not taken
    upd(mk(3, 0), 1'b0, 16'h0000, "R6");  // saturate
    upd(mk(3, 0), 1'b1, 16'h3000, "R6");  // one jump from strong-not-taken: still not taken

    // R7: taken hit replaces target, not-taken hit keeps it
    upd(mk(4, 3), 1'b1, 16'h5000, "R7");
    upd(mk(4, 3), 1'b1, 16'h6000, "R7");
    upd(mk(4, 3), 1'b0, 16'h7000, "R7");

    // R3: same slot, other tag misses, then evicts
    check_pc(mk(9, 3), "R3");
    upd(mk(9, 3), 1'b1, 16'h8000, "R3");
    check_pc(mk(4, 3), "R3");

    // R10: byte offsets inside the word hit the same record
    check_pc(mk(9, 3) | 16'h1, "R10");
    check_pc(mk(9, 3) | 16'h3, "R10");

    // R9 sweep with both schemes: random resolutions over all slots and three tags
    lfsr = 16'hACE1;
    for (int n = 0; n < 300; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      upd(mk(1 + (int'(lfsr[3:2]) % 3), int'(lfsr[1:0])), lfsr[4] ^ lfsr[7],
          {lfsr[15:2], 2'b00}, "R9");
      for (int t = 1; t <= 3; t++)
        for (int i = 0; i < ENT; i++) check_pc(mk(t, i), "R6");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule